// File: doc/BRIEF.md
# Early Receive Interrupt Trigger

This block sits beside the receive path of a network controller. It raises a one-cycle early receive interrupt while a packet is still being copied into host memory, so software can start work before the packet has fully arrived. At each packet start it decides which byte count will fire the interrupt, then compares that count against the running total of bytes already moved to memory. A programmed count of zero means something different: the interrupt fires when the packet's first bus transaction is about to start.

Two fields can supply the firing count. The first is a 12-bit byte-count select with 4-byte granularity. The second is a 4-bit threshold counted in 64-byte units. With the mode bit clear, only packets whose protocol was not recognised use the select field, and recognised packets use the threshold. With the mode bit set, every packet uses the select field. The source and the compare value are captured at packet start. Configuration writes during a packet therefore have no effect on that packet.

Top module: `early_rx_irq`

## Requirements
- R1: After reset, `early_irq` and `cfg_err` are low, and no interrupt occurs until a packet start has been seen.
- R2: With `mode_all`=0 and `proto_known`=0, `early_irq` pulses one cycle after the first cycle in which `bytes_moved` >= the select value with bits 1:0 forced to zero.
- R3: With `mode_all`=0 and `proto_known`=1, `early_irq` pulses one cycle after the first cycle in which `bytes_moved` >= `early_thr` × 64.
- R4: With `mode_all`=1, every packet uses the select value as in R2, whatever `proto_known` is.
- R5: When a packet uses the select field and its masked value is zero, `early_irq` pulses one cycle after `first_xfer` is high, and `bytes_moved` is ignored.
- R6: Bits 1:0 of `sel_cnt` have no effect; for example, values 1 and 3 behave as 0.
- R7: `early_irq` pulses at most once per packet. Only a new `pkt_start` re-arms it.
- R8: `proto_known`, `mode_all`, `sel_cnt` and `early_thr` are sampled only in the `pkt_start` cycle. Changes later in the packet do not affect that packet.
- R9: `cfg_err` goes high in the cycle after a `pkt_start` whose packet uses the select field while `early_thr` is 0. It holds that value until the next packet start.
- R10: A recognised packet with `mode_all`=0 and `early_thr`=0 produces no early interrupt.
- R11: The `pkt_start` cycle never fires. Byte count and `first_xfer` in that cycle are ignored, and a fire pending from the previous packet is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | One-cycle strobe at the start of each received packet |
| proto_known | input | 1 | Protocol of the starting packet was recognised |
| bytes_moved | input | CNT_W | Running count of packet bytes written to host memory |
| first_xfer | input | 1 | The packet's first bus transaction is about to start |
| sel_cnt | input | SEL_W | Byte-count select (bits 1:0 ignored) |
| early_thr | input | THR_W | Early threshold in 64-byte units |
| mode_all | input | 1 | 1: all packets use the select field |
| early_irq | output | 1 | One-cycle early receive interrupt pulse |
| cfg_err | output | 1 | Select field in use while the threshold is zero |

## Verification
The firing condition is registered once, so `early_irq` is due exactly one cycle after the cycle in which the byte count (or `first_xfer`) meets the captured target. `cfg_err` is due one cycle after `pkt_start`. The bench drives inputs on falling edges and raises the byte count by a fixed stride each cycle. At each falling edge it reads the output produced by the preceding rising edge and attributes it to the step driven one cycle earlier. It then compares that step with the first step whose count reaches the target, worked out arithmetically. It sweeps protocol, mode, select and threshold values. After every packet start it scrambles the configuration inputs, so any late sampling shows up as a wrong firing step.

// File: rtl/erx_pkg.sv
package erx_pkg;
  // How the current packet decides to raise its early interrupt
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,  // no early interrupt for this packet
    SRC_FIRST = 2'd1,  // fire at the first bus transaction
    SRC_COUNT = 2'd2   // fire when the byte count reaches the target
  } fire_src_e;
endpackage

// File: rtl/erx_target_sel.sv
module erx_target_sel
  import erx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 12,
  parameter int THR_W    = 4,
  parameter int UNIT_LG2 = 6
) (
  input  logic             proto_known,
  input  logic             mode_all,
  input  logic [SEL_W-1:0] sel_cnt,
  input  logic [THR_W-1:0] early_thr,
  output fire_src_e        src,
  output logic [CNT_W-1:0] target,
  output logic             bad_cfg
);
  localparam int THR_BYTES_W = THR_W + UNIT_LG2;

  logic             use_sel;
  logic [SEL_W-1:0] sel_masked;
  logic [THR_BYTES_W-1:0] thr_bytes;

  assign use_sel    = mode_all | ~proto_known;
  assign sel_masked = {sel_cnt[SEL_W-1:2], 2'b00};
  assign thr_bytes  = {early_thr, {UNIT_LG2{1'b0}}};

  always_comb begin
    src    = SRC_NONE;
    target = '0;
    if (use_sel) begin
      target = CNT_W'(sel_masked);
      src    = (sel_masked == '0) ? SRC_FIRST : SRC_COUNT;
    end else if (early_thr != '0) begin
      target = CNT_W'(thr_bytes);
      src    = SRC_COUNT;
    end
  end

  assign bad_cfg = use_sel && (early_thr == '0);
endmodule

// File: rtl/erx_pkt_ctx.sv
module erx_pkt_ctx
  import erx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  fire_src_e        src_in,
  input  logic [CNT_W-1:0] target_in,
  input  logic             bad_in,
  output fire_src_e        src_q,
  output logic [CNT_W-1:0] target_q,
  output logic             cfg_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= SRC_NONE;
      target_q <= '0;
      cfg_err  <= 1'b0;
    end else if (load) begin
      src_q    <= src_in;
      target_q <= target_in;
      cfg_err  <= bad_in;
    end
  end

  // R8: captured context only changes on a packet start
  p_ctx_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(target_q) && $stable(src_q) && $stable(cfg_err)));

  // R9: error flag reflects the configuration seen at the start
  p_err_latch_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cfg_err == $past(bad_in)));
endmodule

// File: rtl/early_rx_irq.sv
module early_rx_irq
  import erx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SEL_W    = 12,
  parameter int THR_W    = 4,
  parameter int UNIT_LG2 = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_start,
  input  logic             proto_known,
  input  logic [CNT_W-1:0] bytes_moved,
  input  logic             first_xfer,
  input  logic [SEL_W-1:0] sel_cnt,
  input  logic [THR_W-1:0] early_thr,
  input  logic             mode_all,
  output logic             early_irq,
  output logic             cfg_err
);
  fire_src_e        src_d, src_q;
  logic [CNT_W-1:0] target_d, target_q;
  logic             bad_d;
  logic             armed;
  logic             fire_now;

  erx_target_sel #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .THR_W(THR_W), .UNIT_LG2(UNIT_LG2)
  ) u_sel (
    .proto_known(proto_known),
    .mode_all   (mode_all),
    .sel_cnt    (sel_cnt),
    .early_thr  (early_thr),
    .src        (src_d),
    .target     (target_d),
    .bad_cfg    (bad_d)
  );

  erx_pkt_ctx #(.CNT_W(CNT_W)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .load     (pkt_start),
    .src_in   (src_d),
    .target_in(target_d),
    .bad_in   (bad_d),
    .src_q    (src_q),
    .target_q (target_q),
    .cfg_err  (cfg_err)
  );

  always_comb begin
    fire_now = 1'b0;
    if (armed && !pkt_start) begin
      case (src_q)
        SRC_FIRST: fire_now = first_xfer;
        SRC_COUNT: fire_now = (bytes_moved >= target_q);
        default:   fire_now = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      early_irq <= 1'b0;
    end else begin
      early_irq <= fire_now;
      if (pkt_start)     armed <= (src_d != SRC_NONE);
      else if (fire_now) armed <= 1'b0;
    end
  end

  // R1: quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!early_irq && !armed));

  // R7: a pulse leaves the block disarmed
  p_once_r7: assert property (@(posedge clk) disable iff (rst)
    early_irq |-> !armed);

  // R11: a packet start cycle never produces a pulse
  p_start_mute_r11: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> !early_irq);

  // R5: first-transaction mode fires on the strobe
  p_first_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && !pkt_start && src_q == SRC_FIRST && first_xfer) |=> early_irq);

  // R2: byte-count mode fires once the target is reached
  p_count_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !pkt_start && src_q == SRC_COUNT && bytes_moved >= target_q)
      |=> early_irq);
endmodule

// File: tb/sim_early_rx_irq.sv
module sim_early_rx_irq;
  localparam int CNT_W   = 16;
  localparam int NSTEP   = 140;
  localparam int STRIDE  = 8;
  localparam int FX_STEP = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pkt_start = 1'b0;
  logic             proto_known = 1'b0;
  logic [CNT_W-1:0] bytes_moved = '0;
  logic             first_xfer = 1'b0;
  logic [11:0]      sel_cnt = '0;
  logic [3:0]       early_thr = '0;
  logic             mode_all = 1'b0;
  logic             early_irq;
  logic             cfg_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  early_rx_irq u0 (
    .clk(clk), .rst(rst), .pkt_start(pkt_start), .proto_known(proto_known),
    .bytes_moved(bytes_moved), .first_xfer(first_xfer), .sel_cnt(sel_cnt),
    .early_thr(early_thr), .mode_all(mode_all), .early_irq(early_irq),
    .cfg_err(cfg_err)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Step index whose inputs make the pulse appear; -1 when none
  function automatic int exp_step(bit pk, bit md, int sel, int thr);
    int t;
    if (md || !pk) begin
      t = sel & ~3;
      if (t == 0) return FX_STEP;
      return (t + STRIDE - 1) / STRIDE;
    end
    if (thr == 0) return -1;
    return (thr * 64 + STRIDE - 1) / STRIDE;
  endfunction

  task automatic run_pkt(input bit pk, input bit md, input int sel, input int thr);
    int fire_at = -1;
    int fires = 0;
    string tag;
    bit use_sel;
    use_sel = md || !pk;
    tag = !use_sel ? (thr == 0 ? "R10" : "R3") :
          (md ? "R4" : ((sel & ~3) == 0 ? "R5" : "R2"));
    @(negedge clk);
    pkt_start   = 1'b1;
    proto_known = pk;
    mode_all    = md;
    sel_cnt     = 12'(sel);
    early_thr   = 4'(thr);
    bytes_moved = '1;      // R11: ignored in the start cycle
    first_xfer  = 1'b1;
    for (int i = 0; i <= NSTEP; i++) begin
      @(negedge clk);
      if (i == 0) begin
        check("R11 start cycle mute", int'(early_irq), 0);
        // R8: scramble configuration after the start
        proto_known = !pk;
        mode_all    = !md;
        sel_cnt     = 12'h004;
        early_thr   = 4'h1;
      end else if (early_irq) begin
        fires++;
        if (fire_at < 0) fire_at = i - 1;
      end
      if (i == 1) check("R9 cfg_err", int'(cfg_err), int'(use_sel && thr == 0));
      pkt_start = 1'b0;
      if (i < NSTEP) begin
        bytes_moved = CNT_W'(i * STRIDE);
        first_xfer  = (i == FX_STEP);
      end
    end
    check({tag, "/R8 fire step"}, fire_at, exp_step(pk, md, sel, thr));
    check("R7 pulse count", fires, exp_step(pk, md, sel, thr) < 0 ? 0 : 1);
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sels[7] = '{0, 1, 3, 4, 100, 256, 1023};
    int thrs[4] = '{0, 1, 3, 15};
    repeat (3) @(negedge clk);
    bytes_moved = '1;
    first_xfer  = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 reset irq", int'(early_irq), 0);
      check("R1 reset cfg_err", int'(cfg_err), 0);
    end
    first_xfer = 1'b0;

    // R11: pending fire in a start cycle is dropped
    @(negedge clk);
    pkt_start = 1'b1; proto_known = 1'b0; mode_all = 1'b0;
    sel_cnt = 12'd1020; early_thr = 4'd2; bytes_moved = '0;
    @(negedge clk);
    pkt_start = 1'b0; bytes_moved = 16'd100;
    @(negedge clk);
    check("R11 armed before", int'(early_irq), 0);
    pkt_start = 1'b1; proto_known = 1'b1; early_thr = 4'd15;
    bytes_moved = 16'd2000;
    @(negedge clk);
    check("R11 pending dropped", int'(early_irq), 0);
    pkt_start = 1'b0; bytes_moved = 16'd0;
    @(negedge clk);
    check("R11 no late pulse", int'(early_irq), 0);

    // R6 is covered by selects 1 and 3 behaving as 0
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 2; m++)
        foreach (sels[s])
          foreach (thrs[t])
            run_pkt(bit'(p), bit'(m), sels[s], thrs[t]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule